// File: doc/BRIEF.md
# SPI Banked Register Command Engine

This block is the serial front end of a control-register file. A host drives an SPI link in mode 0, MSB first. Chip select starts a transaction. The first byte after select falls is a command that names an operation and a starting register within the bank that a side input selects. Every byte that follows targets the next register, until select rises. There are four operations: plain read, plain write, and two atomic mask operations that set or clear only the bits marked in the byte supplied.

The register file sits inside the block, clocked by the system clock. SPI pins are synchronised into that clock and their edges are detected there. A hardware-side port lets the surrounding logic set and clear bits in any register at any time. When the hardware port and an SPI commit reach the same register in the same cycle, their updates are merged bit by bit, so that a mask operation never disturbs a bit it was not told to touch. An observation port gives the surrounding logic a combinational view of every register.

Top module: `spi_bank_cmd`

## Requirements
- R1: The first byte of a transaction is decoded as op = bits 7:5 and address = bits 4:0. The op codes are 000 read, 010 write, 100 bit-set and 101 bit-clear. The bank input, captured with the command, gives register index bank*32 + address; for example, 4Eh writes address 0Eh and 0Eh reads it.
- R2: In a write, the k-th data byte (k from 0) is stored at address (start + k) mod 32 of the captured bank.
- R3: In a read, the k-th byte after the command shifts out on MISO, MSB first, the value of address (start + k) mod 32, as held when the previous byte completed.
- R4: The 5-bit address wraps from 1Fh to 00h without leaving the bank.
- R5: A bit-set data byte ORs its bits into the addressed register.
- R6: A bit-clear data byte clears the addressed register's bits where the byte holds 1.
- R7: Set and clear leave every unmasked bit as it is, including a bit that the hardware port changes while the transaction is in progress.
- R8: Set and clear aimed at an address flagged in PAIR_MAP (by default all of bank 3) change nothing, while write still works there.
- R9: A command with any other op code changes no register, for all bytes up to the rise of select.
- R10: MISO is 0 while chip select is inactive.
- R11: A hardware update applies (value | set mask) & ~clear mask. In the same cycle as an SPI write to the same register, the SPI byte wins only on the bits it actually changes, and the hardware update applies to the rest.
- R12: After reset every register reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data from host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_miso | output | 1 | Serial data to host, 0 when not selected |
| bank_sel | input | BANK_W | Bank that supplies the upper register index bits |
| hw_we | input | 1 | Hardware bit update strobe |
| hw_addr | input | BANK_W+5 | Register index of the hardware update |
| hw_set | input | 8 | Bits to set on hardware update |
| hw_clr | input | 8 | Bits to clear on hardware update (wins over set) |
| obs_addr | input | BANK_W+5 | Observation read index |
| obs_data | output | 8 | Current value of register obs_addr |

## Verification
The hardest case to reach is a hardware bit change that lands in the middle of a mask operation, after the host has committed to its mask but before the register is written. The bench runs the SPI transfer and a timed hardware pulse side by side. The pulse falls inside the data byte of a bit-set, and a further case holds the hardware port on the target register through an entire write. The final register value then separates a true merge from a read-modify-write.

// File: rtl/spi_bank_cmd_pkg.sv
package spi_bank_cmd_pkg;

   typedef enum logic [2:0] {
      OP_READ  = 3'b000,
      OP_WRITE = 3'b010,
      OP_BSET  = 3'b100,
      OP_BCLR  = 3'b101
   } op_e;

   typedef enum logic [1:0] {
      SQ_CMD  = 2'd0,
      SQ_DATA = 2'd1,
      SQ_DROP = 2'd2
   } seq_st_e;

   localparam int unsigned CMD_ADDR_W = 5;
   localparam int unsigned BYTE_W     = 8;

   function automatic logic op_known(input logic [2:0] code);
      return (code == OP_READ) || (code == OP_WRITE) ||
             (code == OP_BSET) || (code == OP_BCLR);
   endfunction

endpackage

// File: rtl/spi_byte_link.sv
module spi_byte_link
   import spi_bank_cmd_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              mosi,
   input  logic              cs_n,
   input  logic              ld,
   input  logic [BYTE_W-1:0] ld_data,
   output logic              sel,
   output logic              byte_done,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              miso
);

   localparam int unsigned CNT_W = $clog2(BYTE_W);

   // pins carried together through the synchroniser: {cs_n, sck, mosi}
   logic [2:0] sync_q [SYNC_STAGES];

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= 3'b100;
               else        sync_q[s] <= {cs_n, sck, mosi};
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= 3'b100;
               else        sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   logic             sck_s, mosi_s, sck_d;
   logic             sck_rise, sck_fall;
   logic [CNT_W-1:0] bit_cnt;
   logic [BYTE_W-1:0] rx_sh, tx_sh;

   assign sel      = ~sync_q[SYNC_STAGES-1][2];
   assign sck_s    = sync_q[SYNC_STAGES-1][1];
   assign mosi_s   = sync_q[SYNC_STAGES-1][0];
   assign sck_rise = sck_s & ~sck_d;
   assign sck_fall = ~sck_s & sck_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         byte_done <= 1'b0;
         rx_byte   <= '0;
      end else if (!sel) begin
         bit_cnt   <= '0;
         tx_sh     <= '0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= sck_rise && (bit_cnt == CNT_W'(BYTE_W - 1));
         if (sck_rise) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], mosi_s};
            rx_byte <= {rx_sh[BYTE_W-2:0], mosi_s};
            bit_cnt <= bit_cnt + 1'b1;
         end
         if (ld)
            tx_sh <= ld_data;
         else if (sck_fall && (bit_cnt != '0))
            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
   end

   assign miso = sel & tx_sh[BYTE_W-1];

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
   import spi_bank_cmd_pkg::*;
#(
   parameter int unsigned BANK_W = 2,
   parameter logic [(32 << BANK_W)-1:0] PAIR_MAP = '0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         sel,
   input  logic                         byte_done,
   input  logic [BYTE_W-1:0]            rx_byte,
   input  logic [BANK_W-1:0]            bank_sel,
   output logic                         ld,
   output logic [BANK_W+CMD_ADDR_W-1:0] rd_addr,
   output logic                         wr_en,
   output op_e                          wr_op,
   output logic [BANK_W+CMD_ADDR_W-1:0] wr_addr,
   output logic [BYTE_W-1:0]            wr_data
);

   localparam int unsigned RA_W = BANK_W + CMD_ADDR_W;

   seq_st_e               st;
   op_e                   op_q;
   logic [BANK_W-1:0]     bank_q;
   logic [CMD_ADDR_W-1:0] ptr;
   logic [RA_W-1:0]       cur_idx;
   logic                  mask_op;

   assign cur_idx = {bank_q, ptr};
   assign rd_addr = cur_idx;
   assign mask_op = (op_q == OP_BSET) || (op_q == OP_BCLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= SQ_CMD;
         op_q    <= OP_READ;
         bank_q  <= '0;
         ptr     <= '0;
         ld      <= 1'b0;
         wr_en   <= 1'b0;
         wr_op   <= OP_WRITE;
         wr_addr <= '0;
         wr_data <= '0;
      end else if (!sel) begin
         st    <= SQ_CMD;
         ld    <= 1'b0;
         wr_en <= 1'b0;
      end else begin
         ld    <= 1'b0;
         wr_en <= 1'b0;
         if (ld) ptr <= ptr + 1'b1;
         if (byte_done) begin
            unique case (st)
               SQ_CMD: begin
                  ptr    <= rx_byte[CMD_ADDR_W-1:0];
                  bank_q <= bank_sel;
                  if (op_known(rx_byte[7:5])) begin
                     op_q <= op_e'(rx_byte[7:5]);
                     st   <= SQ_DATA;
                     ld   <= (rx_byte[7:5] == OP_READ);
                  end else begin
                     st <= SQ_DROP;
                  end
               end
               SQ_DATA: begin
                  if (op_q == OP_READ) begin
                     ld <= 1'b1;
                  end else begin
                     wr_en   <= !(mask_op && PAIR_MAP[cur_idx]);
                     wr_op   <= op_q;
                     wr_addr <= cur_idx;
                     wr_data <= rx_byte;
                     ptr     <= ptr + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
   import spi_bank_cmd_pkg::*;
#(
   parameter int unsigned RA_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  op_e               wr_op,
   input  logic [RA_W-1:0]   wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              hw_we,
   input  logic [RA_W-1:0]   hw_addr,
   input  logic [BYTE_W-1:0] hw_set,
   input  logic [BYTE_W-1:0] hw_clr,
   input  logic [RA_W-1:0]   rd_addr,
   output logic [BYTE_W-1:0] rd_data,
   input  logic [RA_W-1:0]   obs_addr,
   output logic [BYTE_W-1:0] obs_data,
   output logic [BYTE_W-1:0] wr_q
);

   localparam int unsigned NREG = 1 << RA_W;

   logic [BYTE_W-1:0] regs [NREG];
   logic [BYTE_W-1:0] nxt  [NREG];

   // SPI drives only the bits in spi_m; the hardware result fills the rest
   always_comb begin
      for (int i = 0; i < NREG; i++) begin
         logic [BYTE_W-1:0] hw_v, spi_m, spi_v;
         hw_v = regs[i];
         if (hw_we && (hw_addr == RA_W'(i)))
            hw_v = (regs[i] | hw_set) & ~hw_clr;
         spi_m = '0;
         spi_v = '0;
         if (wr_en && (wr_addr == RA_W'(i))) begin
            unique case (wr_op)
               OP_WRITE: begin spi_m = wr_data ^ regs[i]; spi_v = wr_data; end
               OP_BSET:  begin spi_m = wr_data;           spi_v = '1;      end
               OP_BCLR:  begin spi_m = wr_data;           spi_v = '0;      end
               default:  ;
            endcase
         end
         nxt[i] = (spi_m & spi_v) | (~spi_m & hw_v);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs[i] <= '0;
      end else begin
         for (int i = 0; i < NREG; i++) regs[i] <= nxt[i];
      end
   end

   assign rd_data  = regs[rd_addr];
   assign obs_data = regs[obs_addr];
   assign wr_q     = regs[wr_addr];

endmodule

// File: rtl/spi_bank_cmd.sv
module spi_bank_cmd
   import spi_bank_cmd_pkg::*;
#(
   parameter int unsigned BANK_W      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [(32 << BANK_W)-1:0] PAIR_MAP =
      {32'hFFFF_FFFF, {((32 << BANK_W) - 32){1'b0}}}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_mosi,
   input  logic              spi_cs_n,
   output logic              spi_miso,
   input  logic [BANK_W-1:0] bank_sel,
   input  logic              hw_we,
   input  logic [BANK_W+4:0] hw_addr,
   input  logic [7:0]        hw_set,
   input  logic [7:0]        hw_clr,
   input  logic [BANK_W+4:0] obs_addr,
   output logic [7:0]        obs_data
);

   localparam int unsigned RA_W = BANK_W + CMD_ADDR_W;

   generate
      if (BANK_W < 1 || BANK_W > 3) begin : g_bad_bank
         $error("BANK_W must lie in 1..3");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              sel, byte_done, ld, wr_en;
   logic [BYTE_W-1:0] rx_byte, rd_data, wr_data, wr_q;
   logic [RA_W-1:0]   rd_addr, wr_addr;
   op_e               wr_op;

   spi_byte_link #(.SYNC_STAGES(SYNC_STAGES)) u_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck       (spi_sck),
      .mosi      (spi_mosi),
      .cs_n      (spi_cs_n),
      .ld        (ld),
      .ld_data   (rd_data),
      .sel       (sel),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .miso      (spi_miso)
   );

   spi_cmd_seq #(.BANK_W(BANK_W), .PAIR_MAP(PAIR_MAP)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .bank_sel  (bank_sel),
      .ld        (ld),
      .rd_addr   (rd_addr),
      .wr_en     (wr_en),
      .wr_op     (wr_op),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data)
   );

   bank_regfile #(.RA_W(RA_W)) u_rf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_op    (wr_op),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .hw_we    (hw_we),
      .hw_addr  (hw_addr),
      .hw_set   (hw_set),
      .hw_clr   (hw_clr),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .obs_addr (obs_addr),
      .obs_data (obs_data),
      .wr_q     (wr_q)
   );

endmodule

// File: rtl/spi_bank_cmd_chk.sv
module spi_bank_cmd_chk
   import spi_bank_cmd_pkg::*;
#(
   parameter int unsigned BANK_W = 2,
   parameter logic [(32 << BANK_W)-1:0] PAIR_MAP = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel,
   input logic              spi_miso,
   input logic              wr_en,
   input op_e               wr_op,
   input logic [BANK_W+4:0] wr_addr,
   input logic [7:0]        wr_data,
   input logic [7:0]        wr_q,
   input logic              hw_we,
   input logic [BANK_W+4:0] hw_addr
);

   logic hw_same;
   assign hw_same = hw_we && (hw_addr == wr_addr);

   AST_SET_ORS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_op == OP_BSET) |=> ((wr_q & $past(wr_data)) == $past(wr_data))); // R5

   AST_CLR_ANDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_op == OP_BCLR) |=> ((wr_q & $past(wr_data)) == 8'h00)); // R6

   AST_UNMASKED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_op == OP_BSET || wr_op == OP_BCLR) && !hw_same)
      |=> ((wr_q & ~$past(wr_data)) == ($past(wr_q) & ~$past(wr_data)))); // R7

   AST_PAIR_NO_MASK_OP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && PAIR_MAP[wr_addr]) |-> (wr_op == OP_WRITE)); // R8

   AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |-> !spi_miso); // R10

endmodule

bind spi_bank_cmd spi_bank_cmd_chk #(.BANK_W(BANK_W), .PAIR_MAP(PAIR_MAP)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel      (sel),
   .spi_miso (spi_miso),
   .wr_en    (wr_en),
   .wr_op    (wr_op),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .wr_q     (wr_q),
   .hw_we    (hw_we),
   .hw_addr  (hw_addr)
);

// File: tb/spi_bank_cmd_tb.sv
module spi_bank_cmd_tb;

   localparam int HALF = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
   logic       miso;
   logic [1:0] bank = 2'd0;
   logic       hw_we = 1'b0;
   logic [6:0] hw_addr = '0;
   logic [7:0] hw_set = '0, hw_clr = '0;
   logic [6:0] obs_addr = '0;
   logic [7:0] obs_data;

   int         vec = 0;
   int         bad = 0;
   logic [7:0] mdl [128];
   logic [7:0] txb [40];
   logic [7:0] rxb [40];

   always #5 clk = ~clk;

   spi_bank_cmd u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .spi_sck  (sck),
      .spi_mosi (mosi),
      .spi_cs_n (cs_n),
      .spi_miso (miso),
      .bank_sel (bank),
      .hw_we    (hw_we),
      .hw_addr  (hw_addr),
      .hw_set   (hw_set),
      .hw_clr   (hw_clr),
      .obs_addr (obs_addr),
      .obs_data (obs_data)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      vec++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic done_run();
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   endtask

   task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
      for (int i = 7; i >= 0; i--) begin
         mosi = t[i];
         repeat (HALF) @(negedge clk);
         r[i] = miso;
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic run(input logic [1:0] b, input logic [2:0] op, input logic [4:0] a, input int n);
      logic [7:0] d;
      logic [7:0] r;
      bank = b;
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      xbyte({op, a}, d);
      for (int k = 0; k < n; k++) begin
         xbyte(txb[k], r);
         rxb[k] = r;
      end
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic check_all(input string tag);
      for (int i = 0; i < 128; i++) begin
         obs_addr = 7'(i);
         #1;
         chk($sformatf("%s reg %0d", tag, i), obs_data, mdl[i]);
      end
   endtask

   function automatic int idx(input int b, input int a);
      return b * 32 + (a & 31);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      done_run();
   end

   initial begin
      for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R12 reset contents, R10 quiet output
      check_all("R12 reset");
      chk("R10 idle miso", {7'b0, miso}, 8'h00);

      // R2 / R1 write all four banks
      for (int b = 0; b < 4; b++) begin
         for (int k = 0; k < 32; k++) txb[k] = 8'((b * 37 + k * 11 + 5) & 255);
         run(2'(b), 3'b010, 5'd0, 32);
         for (int k = 0; k < 32; k++) mdl[idx(b, k)] = txb[k];
      end
      check_all("R2 write");

      // R3 read back every bank
      for (int b = 0; b < 4; b++) begin
         run(2'(b), 3'b000, 5'd0, 32);
         for (int k = 0; k < 32; k++) chk($sformatf("R3 read b%0d a%0d", b, k), rxb[k], mdl[idx(b, k)]);
      end
      chk("R10 miso after read", {7'b0, miso}, 8'h00);

      // R1 command byte example: 4Eh writes 0Eh, 0Eh reads it
      txb[0] = 8'h5A;
      run(2'd2, 3'b010, 5'h0E, 1);
      mdl[idx(2, 14)] = 8'h5A;
      run(2'd2, 3'b000, 5'h0E, 1);
      chk("R1 cmd 4Eh/0Eh", rxb[0], 8'h5A);

      // R4 wrap inside a bank
      for (int k = 0; k < 4; k++) txb[k] = 8'(8'hC1 + k);
      run(2'd1, 3'b010, 5'h1E, 4);
      for (int k = 0; k < 4; k++) mdl[idx(1, 30 + k)] = txb[k];
      run(2'd1, 3'b000, 5'h1F, 3);
      for (int k = 0; k < 3; k++) chk($sformatf("R4 wrap read %0d", k), rxb[k], mdl[idx(1, 31 + k)]);
      check_all("R4 wrap");

      // R5 / R6 mask sweeps on banks 0..2
      for (int r = 0; r < 3; r++) begin
         for (int k = 0; k < 32; k++) txb[k] = 8'((k * 29 + r * 71) & 255) ^ 8'h3C;
         run(2'(r), 3'b010, 5'd0, 32);
         for (int k = 0; k < 32; k++) mdl[idx(r, k)] = txb[k];
         for (int k = 0; k < 32; k++) txb[k] = 8'((k * 13 + r * 5) & 255) ^ 8'h81;
         run(2'(r), 3'b100, 5'd0, 32);
         for (int k = 0; k < 32; k++) mdl[idx(r, k)] = mdl[idx(r, k)] | txb[k];
         check_all("R5 set");
         for (int k = 0; k < 32; k++) txb[k] = 8'((k * 7 + r * 97) & 255);
         run(2'(r), 3'b101, 5'd0, 32);
         for (int k = 0; k < 32; k++) mdl[idx(r, k)] = mdl[idx(r, k)] & ~txb[k];
         check_all("R6 clr");
      end

      // R8 paired bank: write works, set and clear suppressed
      for (int k = 0; k < 32; k++) txb[k] = 8'((k * 17 + 3) & 255);
      run(2'd3, 3'b010, 5'd0, 32);
      for (int k = 0; k < 32; k++) mdl[idx(3, k)] = txb[k];
      for (int k = 0; k < 32; k++) txb[k] = 8'hFF;
      run(2'd3, 3'b100, 5'd0, 32);
      check_all("R8 set suppressed");
      run(2'd3, 3'b101, 5'd0, 32);
      check_all("R8 clr suppressed");

      // R9 unknown op codes discard all bytes
      for (int k = 0; k < 4; k++) txb[k] = 8'hA5;
      run(2'd0, 3'b001, 5'd0, 4);
      run(2'd0, 3'b011, 5'd4, 4);
      run(2'd1, 3'b110, 5'd8, 4);
      run(2'd2, 3'b111, 5'd2, 4);
      check_all("R9 unknown op");

      // R7 hardware clears bit 5 mid-way through a set of mask 02h
      txb[0] = 8'h20;
      run(2'd0, 3'b010, 5'h0A, 1);
      txb[0] = 8'h02;
      fork
         run(2'd0, 3'b100, 5'h0A, 1);
         begin
            repeat (HALF * 26) @(negedge clk);
            hw_addr = 7'(idx(0, 10)); hw_clr = 8'h20; hw_set = 8'h00; hw_we = 1'b1;
            @(negedge clk);
            hw_we = 1'b0; hw_clr = 8'h00;
         end
      join
      obs_addr = 7'(idx(0, 10)); #1;
      chk("R7 set with hw clear", obs_data, 8'h02);

      // R7 hardware holds bit 6 set during a set of mask 01h
      txb[0] = 8'h00;
      run(2'd0, 3'b010, 5'h0C, 1);
      hw_addr = 7'(idx(0, 12)); hw_set = 8'h40; hw_we = 1'b1;
      txb[0] = 8'h01;
      run(2'd0, 3'b100, 5'h0C, 1);
      hw_we = 1'b0; hw_set = 8'h00;
      obs_addr = 7'(idx(0, 12)); #1;
      chk("R7 set with hw set", obs_data, 8'h41);

      // R11 hardware-only updates
      txb[0] = 8'h10;
      run(2'd0, 3'b010, 5'h15, 1);
      hw_addr = 7'(idx(0, 21)); hw_set = 8'h81; hw_clr = 8'h00; hw_we = 1'b1;
      @(negedge clk);
      hw_set = 8'h0F; hw_clr = 8'h11;
      @(negedge clk);
      hw_we = 1'b0; hw_set = 8'h00; hw_clr = 8'h00;
      obs_addr = 7'(idx(0, 21)); #1;
      chk("R11 hw update", obs_data, 8'h8E);

      // R11 same-register merge with SPI write
      hw_addr = 7'(idx(0, 13)); hw_set = 8'h08; hw_we = 1'b1;
      txb[0] = 8'hF0;
      run(2'd0, 3'b010, 5'h0D, 1);
      hw_we = 1'b0; hw_set = 8'h00;
      obs_addr = 7'(idx(0, 13)); #1;
      chk("R11 merge hw set", obs_data, 8'hF8);

      hw_addr = 7'(idx(0, 14)); hw_clr = 8'h01; hw_we = 1'b1;
      txb[0] = 8'h0F;
      run(2'd0, 3'b010, 5'h0E, 1);
      hw_we = 1'b0; hw_clr = 8'h00;
      obs_addr = 7'(idx(0, 14)); #1;
      chk("R11 merge hw clr", obs_data, 8'h0E);

      chk("R10 final idle miso", {7'b0, miso}, 8'h00);
      done_run();
   end

endmodule